// File: doc/BRIEF.md
# Trigger Arbiter and Sentence Sequencer

This block sits in front of a sentence playback controller. It decides which of four press inputs gets the playback engine: one sequential key and three stand-alone keys (named tg0, tg1 and tg3). It then emits a one-cycle request carrying the winning source and the sentence number to play. The controller answers with a busy level, and the block uses that level to tell when the engine is occupied and when a sentence has finished.

Each stand-alone key is tied to a fixed sentence. The sequential key draws from a list of up to 16 entries and has three stepping modes:
- play-next: one entry per press.
- play-all: the whole list back to back, each entry launched when the previous one finishes.
- random: a pseudo-random entry that never repeats the previous random pick.

Configuration inputs control how a press made while busy is handled. Under first-key priority the press is dropped. Under last-key priority it preempts the playback. With the on/off option, a press from the key that owns the playback stops it. Press inputs are single-cycle pulses from an upstream debouncer.

Top module: `trig_seq_arb`

## Requirements
- R1: When several presses arrive in one cycle, the winner is tg3 over tg1, tg1 over tg0, and tg0 over the sequential key. `req_src_o` is one-hot: bit 0 is the sequential key, bit 1 tg0, bit 2 tg1, bit 3 tg3.
- R2: The engine is occupied when `busy_i` is high or a request was issued in the previous cycle. While it is occupied with `cfg_last_key_i` low, a press (other than an on/off stop) issues no request and does not advance the sequential index.
- R3: While the engine is occupied with `cfg_last_key_i` high, a press issues a new request for the winning source in the next cycle.
- R4: In play-next mode (`cfg_mode_i` = 0), each started press plays the current entry and then advances the index. After entry `cfg_len_i`-1 the index wraps to 0.
- R5: In play-all mode (`cfg_mode_i` = 1), a press plays entry 0. Each later fall of `busy_i` requests the next entry, until `cfg_len_i` entries have played. A press from any source that takes the engine ends the run.
- R6: In random mode (`cfg_mode_i` = 2), the chosen entry is below `cfg_len_i`. When `cfg_len_i` ≥ 2 it differs from the previous random choice.
- R7: With `cfg_onoff_i` high, a press from the source that owns the current playback, made while the engine is occupied, gives a one-cycle `stop_vld_o` and no request, and ends any play-all run.
- R8: A request lasts one cycle, the cycle after the press or busy fall that caused it. Sentence numbers: sequential entry i maps to 16+3·i; tg0, tg1 and tg3 map to 1, 2 and 3.
- R9: After synchronous reset, `req_vld_o` and `stop_vld_o` are low and the sequential index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_key_i | input | 1 | Sequential key press pulse |
| sa_key_i | input | 3 | Stand-alone press pulses: bit 0 tg0, bit 1 tg1, bit 2 tg3 |
| busy_i | input | 1 | Playback controller busy level |
| cfg_last_key_i | input | 1 | 1 = last-key priority, 0 = first-key priority |
| cfg_onoff_i | input | 1 | Enables stop on a repeated press by the owner |
| cfg_mode_i | input | 2 | Sequential mode: 0 next, 1 all, 2 random |
| cfg_len_i | input | 5 | Number of list entries, 1 to 16 |
| req_vld_o | output | 1 | Request strobe |
| req_src_o | output | 4 | One-hot source of the request |
| req_sent_o | output | 8 | Sentence number requested |
| stop_vld_o | output | 1 | Stop strobe |

## Verification
The assertions assume the following about the inputs:
- Presses are single-cycle pulses.
- The controller raises `busy_i` no later than the cycle after a request strobe.
- `cfg_len_i` stays between 1 and 16 and does not change while a play-all run is in progress.

The bench keeps to these rules. It drives `busy_i` itself, raising it at the falling edge where the request is observed. It changes the list length only inside a reset. It inserts one idle cycle after each request before the next press, so a press is never taken as a preemption by accident.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_NEXT = 2'd0,
    SEQ_ALL  = 2'd1,
    SEQ_RAND = 2'd2
  } seq_mode_e;

  localparam int NUM_SRC = 4;
  localparam int SRC_SEQ = 0;

endpackage

// File: rtl/trig_prio.sv
module trig_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // higher index wins: later iterations override earlier ones
  always_comb begin
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_lfsr.sv
module seq_lfsr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state_o
);
  always_ff @(posedge clk) begin
    if (rst) state_o <= {{(W-1){1'b0}}, 1'b1};
    else     state_o <= {state_o[W-2:0], state_o[W-1] ^ state_o[W-2]};
  end
endmodule

// File: rtl/seq_stepper.sv
module seq_stepper
  import trig_seq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [IDX_W-1:0] rnd_i,
  input  logic             take_i,
  output logic [IDX_W-1:0] pick_o
);
  logic [IDX_W-1:0] idx_q, last_q, nxt, ralt;
  logic [LEN_W-1:0] inc, rmod, rinc;

  always_comb begin
    inc  = {1'b0, idx_q} + LEN_W'(1);
    nxt  = (inc >= len_i) ? '0 : inc[IDX_W-1:0];
    rmod = (len_i == '0) ? '0 : ({1'b0, rnd_i} % len_i);
    rinc = rmod + LEN_W'(1);
    if ((len_i > LEN_W'(1)) && (rmod[IDX_W-1:0] == last_q))
      ralt = (rinc >= len_i) ? '0 : rinc[IDX_W-1:0];
    else
      ralt = rmod[IDX_W-1:0];
    case (seq_mode_e'(mode_i))
      SEQ_ALL:  pick_o = '0;
      SEQ_RAND: pick_o = ralt;
      default:  pick_o = idx_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      last_q <= '0;
    end else if (take_i) begin
      if (seq_mode_e'(mode_i) == SEQ_RAND) last_q <= ralt;
      else if (seq_mode_e'(mode_i) != SEQ_ALL) idx_q <= nxt;
    end
  end
endmodule

// File: rtl/trig_seq_arb.sv
module trig_seq_arb
  import trig_seq_pkg::*;
#(
  parameter int SENT_W   = 8,
  parameter int LIST_MAX = 16,
  parameter int SEQ_BASE = 16,
  parameter int SEQ_STEP = 3,
  parameter logic [3*SENT_W-1:0] SA_SENT = {8'd3, 8'd2, 8'd1},
  localparam int IDX_W = $clog2(LIST_MAX),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_key_i,
  input  logic [2:0]        sa_key_i,
  input  logic              busy_i,
  input  logic              cfg_last_key_i,
  input  logic              cfg_onoff_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  output logic              req_vld_o,
  output logic [3:0]        req_src_o,
  output logic [SENT_W-1:0] req_sent_o,
  output logic              stop_vld_o
);
  logic [NUM_SRC-1:0] press, grant, owner_q;
  logic [IDX_W-1:0]   rnd, seq_pick, all_pos_q;
  logic [LEN_W-1:0]   all_next;
  logic [SENT_W-1:0]  sa_sent;
  logic [SENT_W-1:0]  seq_tab [LIST_MAX];
  logic busy_q, all_run_q, occupied, busy_fall, any_press;
  logic do_start, do_stop, do_cont, do_end, seq_take;

  for (genvar i = 0; i < LIST_MAX; i++) begin : g_tab
    assign seq_tab[i] = SENT_W'(SEQ_BASE + i * SEQ_STEP);
  end

  assign press = {sa_key_i, seq_key_i};

  trig_prio #(.N(NUM_SRC)) u_prio (.req_i(press), .gnt_o(grant));

  seq_lfsr #(.W(IDX_W)) u_lfsr (.clk(clk), .rst(rst), .state_o(rnd));

  seq_stepper #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_step (
    .clk(clk), .rst(rst), .mode_i(cfg_mode_i), .len_i(cfg_len_i),
    .rnd_i(rnd), .take_i(seq_take), .pick_o(seq_pick)
  );

  always_comb begin
    occupied  = busy_i | req_vld_o;
    busy_fall = busy_q & ~busy_i;
    any_press = |grant;
    all_next  = {1'b0, all_pos_q} + LEN_W'(1);
    do_stop   = any_press & occupied & cfg_onoff_i & (grant == owner_q);
    do_start  = any_press & ~do_stop & (~occupied | cfg_last_key_i);
    do_cont   = ~any_press & all_run_q & busy_fall & (all_next < cfg_len_i);
    do_end    = ~any_press & all_run_q & busy_fall & ~(all_next < cfg_len_i);
    seq_take  = do_start & grant[SRC_SEQ];
    if (grant[3])      sa_sent = SA_SENT[2*SENT_W +: SENT_W];
    else if (grant[2]) sa_sent = SA_SENT[SENT_W +: SENT_W];
    else               sa_sent = SA_SENT[0 +: SENT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      req_vld_o  <= 1'b0;
      req_src_o  <= '0;
      req_sent_o <= '0;
      stop_vld_o <= 1'b0;
      owner_q    <= '0;
      all_run_q  <= 1'b0;
      all_pos_q  <= '0;
    end else begin
      busy_q     <= busy_i;
      req_vld_o  <= 1'b0;
      stop_vld_o <= 1'b0;
      if (do_start) begin
        req_vld_o  <= 1'b1;
        req_src_o  <= grant;
        owner_q    <= grant;
        req_sent_o <= grant[SRC_SEQ] ? seq_tab[seq_pick] : sa_sent;
        all_run_q  <= grant[SRC_SEQ] && (seq_mode_e'(cfg_mode_i) == SEQ_ALL);
        all_pos_q  <= '0;
      end else if (do_cont) begin
        req_vld_o  <= 1'b1;
        req_src_o  <= NUM_SRC'(1) << SRC_SEQ;
        req_sent_o <= seq_tab[all_next[IDX_W-1:0]];
        all_pos_q  <= all_next[IDX_W-1:0];
      end else if (do_end) begin
        all_run_q <= 1'b0;
      end else if (do_stop) begin
        stop_vld_o <= 1'b1;
        all_run_q  <= 1'b0;
        owner_q    <= '0;
      end
    end
  end
endmodule

// File: rtl/trig_seq_arb_chk.sv
module trig_seq_arb_chk #(
  parameter int IDX_W = 4,
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             seq_key_i,
  input logic [2:0]       sa_key_i,
  input logic             busy_i,
  input logic             cfg_last_key_i,
  input logic             cfg_onoff_i,
  input logic [1:0]       cfg_mode_i,
  input logic [LEN_W-1:0] cfg_len_i,
  input logic             req_vld_o,
  input logic [3:0]       req_src_o,
  input logic             stop_vld_o,
  input logic [IDX_W-1:0] seq_pick
);
  // R1
  tg3_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sa_key_i[2]) && req_vld_o) |-> req_src_o[3]);

  // R2
  first_key_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_last_key_i && !cfg_onoff_i && busy_i && (seq_key_i || (|sa_key_i)))
      |=> (!req_vld_o && !stop_vld_o));

  // R3
  last_key_take_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_last_key_i && !cfg_onoff_i && (seq_key_i || (|sa_key_i))) |=> req_vld_o);

  // R6
  rand_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode_i == 2'd2 && cfg_len_i != '0) |-> ({1'b0, seq_pick} < cfg_len_i));

  // R7
  stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    stop_vld_o |-> !req_vld_o);

  // R8
  src_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    req_vld_o |-> ($countones(req_src_o) == 1));
endmodule

bind trig_seq_arb trig_seq_arb_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .seq_key_i(seq_key_i), .sa_key_i(sa_key_i),
  .busy_i(busy_i), .cfg_last_key_i(cfg_last_key_i), .cfg_onoff_i(cfg_onoff_i),
  .cfg_mode_i(cfg_mode_i), .cfg_len_i(cfg_len_i), .req_vld_o(req_vld_o),
  .req_src_o(req_src_o), .stop_vld_o(stop_vld_o), .seq_pick(seq_pick)
);

// File: tb/trig_seq_arb_tb.sv
`timescale 1ns/1ps
module trig_seq_arb_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       seq_key = 1'b0;
  logic [2:0] sa_key = '0;
  logic       busy = 1'b0;
  logic       cfg_last = 1'b0;
  logic       cfg_onoff = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [4:0] cfg_len = 5'd5;
  logic       req_vld, stop_vld;
  logic [3:0] req_src;
  logic [7:0] req_sent;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trig_seq_arb u_dut (
    .clk(clk), .rst(rst), .seq_key_i(seq_key), .sa_key_i(sa_key),
    .busy_i(busy), .cfg_last_key_i(cfg_last), .cfg_onoff_i(cfg_onoff),
    .cfg_mode_i(cfg_mode), .cfg_len_i(cfg_len), .req_vld_o(req_vld),
    .req_src_o(req_src), .req_sent_o(req_sent), .stop_vld_o(stop_vld)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // p = {tg3, tg1, tg0, seq}; returns at the negedge where the result is visible
  task automatic pulse(input logic [3:0] p);
    @(negedge clk);
    seq_key = p[0]; sa_key = p[3:1];
    @(negedge clk);
    seq_key = 1'b0; sa_key = '0;
  endtask

  task automatic gap();
    @(negedge clk);
  endtask

  task automatic expect_req(input string tag, input logic [3:0] src, input int sent);
    chk(req_vld === 1'b1, {tag, " vld"}, int'(req_vld), 1);
    chk(req_src === src, {tag, " src"}, int'(req_src), int'(src));
    chk(int'(req_sent) == sent, {tag, " sent"}, int'(req_sent), sent);
  endtask

  function automatic int seq_sent(input int e);
    return (16 + 3 * e) % 256;
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int m_idx;
    int prev;
    int ent;
    do_reset();
    gap();
    // R9 reset state
    chk(req_vld === 1'b0, "R9 req after reset", int'(req_vld), 0);
    chk(stop_vld === 1'b0, "R9 stop after reset", int'(stop_vld), 0);

    // R4 play-next sweep over every list length, R9 index starts at 0
    cfg_mode = 2'd0;
    for (int len = 1; len <= 16; len++) begin
      cfg_len = 5'(len);
      do_reset();
      m_idx = 0;
      for (int k = 0; k < len + 2; k++) begin
        pulse(4'b0001);
        expect_req("R4 next", 4'b0001, seq_sent(m_idx));
        m_idx = (m_idx + 1 >= len) ? 0 : m_idx + 1;
        gap();
      end
    end

    // R1 priority over all press combinations, R8 sentence mapping
    cfg_len = 5'd16;
    do_reset();
    m_idx = 0;
    for (int p = 1; p < 16; p++) begin
      pulse(4'(p));
      if (p[3])      expect_req("R1 tg3", 4'b1000, 3);
      else if (p[2]) expect_req("R1 tg1", 4'b0100, 2);
      else if (p[1]) expect_req("R1 tg0", 4'b0010, 1);
      else begin
        expect_req("R1 seq", 4'b0001, seq_sent(m_idx));
        m_idx++;
      end
      gap();
      chk(req_vld === 1'b0, "R8 single cycle", int'(req_vld), 0);
    end

    // R2 first-key: presses while busy are dropped, index unchanged
    busy = 1'b1; gap();
    pulse(4'b1111);
    chk(req_vld === 1'b0, "R2 busy ignore all", int'(req_vld), 0);
    pulse(4'b0001);
    chk(req_vld === 1'b0, "R2 busy ignore seq", int'(req_vld), 0);
    busy = 1'b0; gap(); gap();
    pulse(4'b0001);
    expect_req("R2 index kept", 4'b0001, seq_sent(m_idx));
    m_idx++;
    gap();

    // R3 last-key preemption
    cfg_last = 1'b1;
    pulse(4'b0010);
    expect_req("R3 start tg0", 4'b0010, 1);
    busy = 1'b1; gap();
    pulse(4'b1000);
    expect_req("R3 preempt tg3", 4'b1000, 3);
    pulse(4'b0001);
    expect_req("R3 preempt seq", 4'b0001, seq_sent(m_idx));
    m_idx++;
    busy = 1'b0; gap(); gap();
    cfg_last = 1'b0;

    // R7 on/off toggling by the owner
    cfg_onoff = 1'b1;
    pulse(4'b0100);
    expect_req("R7 start tg1", 4'b0100, 2);
    busy = 1'b1; gap();
    pulse(4'b0010);
    chk(req_vld === 1'b0, "R7 non-owner req", int'(req_vld), 0);
    chk(stop_vld === 1'b0, "R7 non-owner stop", int'(stop_vld), 0);
    pulse(4'b0100);
    chk(stop_vld === 1'b1, "R7 owner stop", int'(stop_vld), 1);
    chk(req_vld === 1'b0, "R7 owner no req", int'(req_vld), 0);
    gap();
    chk(stop_vld === 1'b0, "R7 stop one cycle", int'(stop_vld), 0);
    busy = 1'b0; gap(); gap();
    cfg_onoff = 1'b0;

    // R5 play-all over a 4-entry list
    cfg_mode = 2'd1; cfg_len = 5'd4;
    do_reset();
    pulse(4'b0001);
    expect_req("R5 all first", 4'b0001, seq_sent(0));
    for (int k = 1; k < 4; k++) begin
      busy = 1'b1; repeat (3) gap();
      busy = 1'b0; gap();
      expect_req("R5 all step", 4'b0001, seq_sent(k));
    end
    busy = 1'b1; repeat (3) gap();
    busy = 1'b0; gap();
    chk(req_vld === 1'b0, "R5 all ends", int'(req_vld), 0);
    gap();

    // R5 preempted run does not continue
    cfg_last = 1'b1;
    pulse(4'b0001);
    expect_req("R5 all restart", 4'b0001, seq_sent(0));
    busy = 1'b1; gap();
    pulse(4'b0100);
    expect_req("R5 preempt tg1", 4'b0100, 2);
    gap();
    busy = 1'b0; gap();
    chk(req_vld === 1'b0, "R5 no resume", int'(req_vld), 0);
    gap();
    cfg_last = 1'b0;

    // R7 stop ends a play-all run
    cfg_onoff = 1'b1;
    pulse(4'b0001);
    expect_req("R7 all start", 4'b0001, seq_sent(0));
    busy = 1'b1; gap();
    pulse(4'b0001);
    chk(stop_vld === 1'b1, "R7 all stop", int'(stop_vld), 1);
    busy = 1'b0; gap();
    chk(req_vld === 1'b0, "R7 all no resume", int'(req_vld), 0);
    gap();
    cfg_onoff = 1'b0;

    // R6 random picks stay in range and never repeat
    cfg_mode = 2'd2;
    for (int len = 1; len <= 16; len++) begin
      cfg_len = 5'(len);
      do_reset();
      prev = -1;
      for (int k = 0; k < 20; k++) begin
        repeat (k % 3) gap();
        pulse(4'b0001);
        ent = (int'(req_sent) - 16) / 3;
        chk(req_vld === 1'b1 && req_src === 4'b0001, "R6 rand vld", int'(req_vld), 1);
        chk(int'(req_sent) >= 16 && ent < len && (int'(req_sent) - 16) % 3 == 0,
            "R6 rand range", ent, len - 1);
        if (len > 1) chk(ent != prev, "R6 rand repeat", ent, prev);
        prev = ent;
        gap();
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule